// File: doc/BRIEF.md
# Burst SRAM Write-Start Controller

This block is the front end of a synchronous burst SRAM with a small internal array. An access can begin in one of two ways. A processor-side strobe starts it, and the write enables are then sampled on the following edge. A controller-side strobe starts it, and the write is taken on that same edge. Either way, the block captures the address and seeds a two-bit burst counter. It decodes the global and per-lane write enables and updates only the lanes that are enabled.

The shared data bus appears as separate data-in, data-out and drive-enable ports. The drive enable is held off whenever any write enable is presented, whatever the output-enable pin says.

After a start, every cycle with both start strobes high is a continuation cycle. In such a cycle the block writes to the current burst address if the enables request it. When the advance strobe is low, the burst address then steps in either linear or interleaved order. Reads are flow-through: the data output shows the word at the current burst address.

Top module: `bsw_top`

## Requirements
- R1: With `procStartN` low and `chipSelN` low on an edge, the address is captured and becomes the current burst address. The next cycle's read output shows that word.
- R2: In a processor-start cycle, `globalWrN`, `byteWrN`, `laneWrN` and `advN` have no effect. Nothing is written on that edge and the burst address is not advanced.
- R3: On a continuation edge after a processor start, `globalWrN` low writes all four 8-bit lanes from `dataIn`. Lane i is bits [8i+7:8i].
- R4: On a write edge with `globalWrN` high and `byteWrN` low, lane i is written only when `laneWrN[i]` is low. The other lanes keep their old contents.
- R5: With `globalWrN` and `byteWrN` both high, nothing is written, whatever `laneWrN` holds.
- R6: With `ctrlStartN` low, `procStartN` high and `chipSelN` low on an edge, the write enables are applied on that same edge at the presented address.
- R7: `advN` is ignored in a controller-start cycle. The next cycle reads the presented address.
- R8: When both start strobes are low with chip select active, the access is treated as a processor start. No write occurs on that edge.
- R9: Each continuation edge with `advN` low steps the low two address bits. With `linearMode`=1 they become (start+n) mod 4. With `linearMode`=0 they become start XOR n.
- R10: `dataOe` is high only when the block is selected, `outEnN` is low, and no write enable is active (`globalWrN` low, or `byteWrN` low with any `laneWrN` bit low).
- R11: A start strobe with `chipSelN` high deselects the block. `dataOe` stays low and continuation writes are ignored until the next selected start.
- R12: After reset the block is deselected and `dataOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procStartN | input | 1 | Processor-side start strobe, active low, has priority |
| ctrlStartN | input | 1 | Controller-side start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| chipSelN | input | 1 | Chip select, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Per-lane write qualifier, active low |
| laneWrN | input | 4 | Per-lane write selects, active low |
| outEnN | input | 1 | Output enable, active low |
| linearMode | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | 6 | Word address |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Read data at the current burst address |
| dataOe | output | 1 | Data bus drive enable |

## Verification
A corrupted burst counter or base address shows up in the very next cycle as the wrong word on `dataOut` during a burst read. A stuck select flag shows up at once as `dataOe` disagreeing with `outEnN`. Lane-mask or write-timing faults stay hidden in the array until the word is read back. For that reason, every write scenario ends with a read of the affected address, compared against a reference array. Unselected lanes and first-cycle junk data are chosen so that they differ from the expected word.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int ADDR_W  = 6;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BURST_W = 2;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef struct packed {
    logic              wrEn;
    logic [LANES-1:0]  laneWe;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
    logic              driveOk;
  } bswStrb_t;
endpackage

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advN,
  input  logic              chipSelN,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              outEnN,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addr,
  output bswStrb_t          strb
);
  logic              selQ;
  logic [ADDR_W-1:0] baseQ;
  logic [BURST_W-1:0] cntQ;
  logic [BURST_W-1:0] lowSeq;
  logic [ADDR_W-1:0] curAddr;
  logic [LANES-1:0]  laneReq;
  logic              procStart, ctrlStart, deselect, contCycle, anyReq;

  assign procStart = !procStartN && !chipSelN;
  assign ctrlStart = procStartN && !ctrlStartN && !chipSelN;
  assign deselect  = chipSelN && (!procStartN || !ctrlStartN);
  assign contCycle = procStartN && ctrlStartN && selQ;

  for (genvar g = 0; g < LANES; g++) begin : gLaneReq
    assign laneReq[g] = !globalWrN || (!byteWrN && !laneWrN[g]);
  end
  assign anyReq = |laneReq;

  always_comb begin
    if (linearMode) lowSeq = baseQ[BURST_W-1:0] + cntQ;
    else            lowSeq = baseQ[BURST_W-1:0] ^ cntQ;
  end
  assign curAddr = {baseQ[ADDR_W-1:BURST_W], lowSeq};

  always_comb begin
    strb.wrEn    = (ctrlStart || contCycle) && anyReq;
    strb.laneWe  = strb.wrEn ? laneReq : '0;
    strb.wrAddr  = ctrlStart ? addr : curAddr;
    strb.rdAddr  = curAddr;
    strb.driveOk = selQ && !outEnN && !anyReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      baseQ <= '0;
      cntQ  <= '0;
    end else if (procStart || ctrlStart) begin
      selQ  <= 1'b1;
      baseQ <= addr;
      cntQ  <= '0;
    end else if (deselect) begin
      selQ  <= 1'b0;
    end else if (contCycle && !advN) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  AST_PROC_LOADS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    procStart |=> strb.rdAddr == $past(addr)); // R1
  AST_PROC_FIRST_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    procStart |-> !strb.wrEn); // R2
  AST_CTRL_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStart && !advN) |=> strb.rdAddr == $past(addr)); // R7
  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (!procStartN && !ctrlStartN && !chipSelN) |-> !strb.wrEn); // R8
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (contCycle && !advN) |=> strb.rdAddr != $past(strb.rdAddr)); // R9
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    deselect |=> !strb.driveOk && !strb.wrEn); // R11
endmodule

// File: rtl/bsw_datapath.sv
module bsw_datapath
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bswStrb_t          strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : gLaneWr
    always_ff @(posedge clk) begin
      if (strb.laneWe[g])
        mem[strb.wrAddr][g*LANE_W +: LANE_W] <= dataIn[g*LANE_W +: LANE_W];
    end
  end

  assign dataOut = mem[strb.rdAddr];
  assign dataOe  = strb.driveOk;

  logic              prevWr;
  logic [LANES-1:0]  prevLaneWe;
  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevWord;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWr     <= 1'b0;
      prevLaneWe <= '0;
      prevAddr   <= '0;
      prevWord   <= '0;
    end else begin
      prevWr     <= strb.wrEn;
      prevLaneWe <= strb.laneWe;
      prevAddr   <= strb.wrAddr;
      prevWord   <= mem[strb.wrAddr];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    AST_UNSEL_LANE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (prevWr && !prevLaneWe[g]) |->
        mem[prevAddr][g*LANE_W +: LANE_W] == prevWord[g*LANE_W +: LANE_W]); // R4
  end

  AST_BUS_OFF_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> !dataOe); // R10
endmodule

// File: rtl/bsw_top.sv
module bsw_top
  import bsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStartN,
  input  logic              ctrlStartN,
  input  logic              advN,
  input  logic              chipSelN,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              outEnN,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  bswStrb_t strb;

  bsw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .procStartN(procStartN), .ctrlStartN(ctrlStartN),
    .advN(advN), .chipSelN(chipSelN), .globalWrN(globalWrN), .byteWrN(byteWrN),
    .laneWrN(laneWrN), .outEnN(outEnN), .linearMode(linearMode), .addr(addr),
    .strb(strb)
  );

  bsw_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/tb_bsw_top.sv
module tb_bsw_top;
  import bsw_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, procStartN, ctrlStartN, advN, chipSelN, globalWrN, byteWrN, outEnN, linearMode;
  logic [LANES-1:0]  laneWrN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataIn, dataOut;
  logic              dataOe;

  bsw_top dut (
    .clk(clk), .rstN(rstN), .procStartN(procStartN), .ctrlStartN(ctrlStartN),
    .advN(advN), .chipSelN(chipSelN), .globalWrN(globalWrN), .byteWrN(byteWrN),
    .laneWrN(laneWrN), .outEnN(outEnN), .linearMode(linearMode), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  int nRun = 0;
  int nFail = 0;
  logic [DATA_W-1:0] refMem [DEPTH];

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    procStartN = 1'b1; ctrlStartN = 1'b1; advN = 1'b1; chipSelN = 1'b0;
    globalWrN = 1'b1; byteWrN = 1'b1; laneWrN = '1; outEnN = 1'b1;
  endtask

  task automatic refWrite(int a, logic g, logic b, logic [LANES-1:0] bw, logic [DATA_W-1:0] d);
    for (int i = 0; i < LANES; i++)
      if (!g || (!b && !bw[i])) refMem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
  endtask

  task automatic readBack(int a, string tag);
    @(negedge clk); idle(); procStartN = 1'b0; addr = ADDR_W'(a);
    @(negedge clk); idle(); outEnN = 1'b0;
    #1;
    check({tag, " oe"}, DATA_W'(dataOe), DATA_W'(1));
    check({tag, " data"}, dataOut, refMem[a]);
  endtask

  task automatic procWrite(int a, logic g, logic b, logic [LANES-1:0] bw, logic [DATA_W-1:0] d);
    @(negedge clk); idle(); procStartN = 1'b0; addr = ADDR_W'(a);
    globalWrN = 1'b0; advN = 1'b0; dataIn = ~d;
    @(negedge clk); idle(); globalWrN = g; byteWrN = b; laneWrN = bw; dataIn = d;
    refWrite(a, g, b, bw, d);
    @(negedge clk); idle();
  endtask

  task automatic ctrlWrite(int a, logic g, logic b, logic [LANES-1:0] bw, logic [DATA_W-1:0] d);
    @(negedge clk); idle(); ctrlStartN = 1'b0; addr = ADDR_W'(a);
    globalWrN = g; byteWrN = b; laneWrN = bw; dataIn = d; advN = 1'b0;
    refWrite(a, g, b, bw, d);
    @(negedge clk); idle();
  endtask

  task automatic testReset();
    rstN = 1'b0; idle(); outEnN = 1'b0; linearMode = 1'b1; addr = '0; dataIn = '0;
    repeat (3) @(negedge clk);
    check("R12 oe in reset", DATA_W'(dataOe), '0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R12 oe after reset", DATA_W'(dataOe), '0);
    for (int i = 0; i < DEPTH; i++)
      ctrlWrite(i, 1'b0, 1'b1, '1, (DATA_W'(i) * 32'h01010101) ^ 32'hA5C3_0000);
  endtask

  task automatic testProcFull();
    procWrite(5, 1'b0, 1'b1, '1, 32'h1122_3344);
    readBack(5, "R3 global write");
  endtask

  task automatic testProcIgnore();
    @(negedge clk); idle(); procStartN = 1'b0; addr = 6'd9;
    globalWrN = 1'b0; byteWrN = 1'b0; laneWrN = '0; advN = 1'b0; dataIn = 32'hDEAD_BEEF;
    @(negedge clk); idle(); outEnN = 1'b0;
    #1;
    check("R2 address not advanced", dataOut, refMem[9]);
    readBack(9, "R2 no write on start");
  endtask

  task automatic testByte();
    procWrite(12, 1'b1, 1'b0, 4'b1010, 32'hCAFE_F00D);
    readBack(12, "R4 lanes 0,2");
    ctrlWrite(14, 1'b1, 1'b0, 4'b0111, 32'h7788_99AA);
    readBack(14, "R4 lane 3");
  endtask

  task automatic testNoEnable();
    procWrite(13, 1'b1, 1'b1, 4'b0000, 32'h1234_5678);
    readBack(13, "R5 no enables");
  endtask

  task automatic testCtrl();
    ctrlWrite(20, 1'b0, 1'b1, '1, 32'h5A5A_0F0F);
    readBack(20, "R6 global");
    ctrlWrite(21, 1'b1, 1'b0, 4'b0110, 32'h0102_0304);
    readBack(21, "R6 byte");
  endtask

  task automatic testCtrlAdv();
    @(negedge clk); idle(); ctrlStartN = 1'b0; addr = 6'd22; advN = 1'b0;
    @(negedge clk); idle(); outEnN = 1'b0;
    #1;
    check("R7 adv ignored", dataOut, refMem[22]);
  endtask

  task automatic testPriority();
    @(negedge clk); idle(); procStartN = 1'b0; ctrlStartN = 1'b0; addr = 6'd24;
    globalWrN = 1'b0; dataIn = 32'hBAD0_BAD0;
    @(negedge clk); idle();
    readBack(24, "R8 priority");
  endtask

  task automatic testBurst(logic lin, int start);
    @(negedge clk); idle(); linearMode = lin; procStartN = 1'b0; addr = ADDR_W'(start);
    @(negedge clk); idle(); outEnN = 1'b0; advN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int lo, ea;
      lo = lin ? ((start + k) % 4) : ((start % 4) ^ k);
      ea = (start / 4) * 4 + lo;
      #1;
      check(lin ? "R9 linear" : "R9 interleaved", dataOut, refMem[ea]);
      @(negedge clk); idle(); outEnN = 1'b0; advN = 1'b0;
    end
    idle(); linearMode = 1'b1;
  endtask

  task automatic testOe();
    @(negedge clk); idle(); procStartN = 1'b0; addr = 6'd30;
    @(negedge clk); idle(); outEnN = 1'b0; globalWrN = 1'b0; dataIn = 32'h0BAD_CAFE;
    refWrite(30, 1'b0, 1'b1, '1, 32'h0BAD_CAFE);
    #1; check("R10 off on global write", DATA_W'(dataOe), '0);
    @(negedge clk); idle(); outEnN = 1'b0; byteWrN = 1'b0; laneWrN = 4'b1110;
    dataIn = 32'h0000_0099;
    refWrite(30, 1'b1, 1'b0, 4'b1110, 32'h0000_0099);
    #1; check("R10 off on byte write", DATA_W'(dataOe), '0);
    @(negedge clk); idle(); outEnN = 1'b1;
    #1; check("R10 off with outEn high", DATA_W'(dataOe), '0);
    @(negedge clk); idle(); outEnN = 1'b0;
    #1; check("R10 on", DATA_W'(dataOe), DATA_W'(1));
    check("R10 data", dataOut, refMem[30]);
  endtask

  task automatic testDeselect();
    @(negedge clk); idle(); procStartN = 1'b0; addr = 6'd50;
    @(negedge clk); idle(); ctrlStartN = 1'b0; chipSelN = 1'b1; addr = 6'd51;
    @(negedge clk); idle(); outEnN = 1'b0; globalWrN = 1'b0; dataIn = 32'hFFFF_0000;
    @(negedge clk); idle(); outEnN = 1'b0;
    #1; check("R11 oe low when deselected", DATA_W'(dataOe), '0);
    readBack(50, "R11 no write when deselected");
  endtask

  initial begin
    testReset();
    testProcFull();
    testProcIgnore();
    testByte();
    testNoEnable();
    testCtrl();
    testCtrlAdv();
    testPriority();
    testBurst(1'b1, 34);
    testBurst(1'b0, 33);
    testBurst(1'b0, 38);
    testOe();
    testDeselect();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule